// File: doc/BRIEF.md
# Delta-Modulation Capacitance Tracking Controller

This block is the digital loop of a delta-modulation capacitance converter. It keeps an up/down estimate and steers it from a single comparator bit that an analog front end returns each iteration. When the bit is 1 the estimate moves up by the current step. When the bit is 0 it moves down. A conversion is a number of cycles, and each cycle is a number of comparison iterations. The step starts at a programmable initial value. It is halved at every cycle boundary unless a fixed-step mode is chosen.

The estimate is kept within the full scale of a selectable output resolution. An optional lower and upper baseline can narrow that range further, and the estimate starts at the middle of the permitted range. A start pulse while idle captures all settings and raises busy. After the last iteration, a one-cycle done pulse comes with a registered result that holds until the next conversion ends. A setting of zero for the iteration count, the cycle count or the initial step picks a built-in default.

Top module: `dm_track_ctrl`

## Requirements
- R1: After reset, busy is 0, done is 0 and result is 0.
- R2: A start sampled while busy is 0 sets busy on the next edge. busy then stays 1 for exactly iterations×cycles clock cycles, one comparison per cycle. A start sampled while busy is 1 is ignored.
- R3: done is 1 for exactly one cycle, the cycle after the last cycle in which busy is 1. result changes only together with done and otherwise holds its value.
- R4: In each busy cycle, cmp_bit=1 adds the current step to the estimate and cmp_bit=0 subtracts it.
- R5: res_sel encodes the resolution: 0 is 10 bits, 1 is 12, 2 is 14 and 3 is 16. The estimate saturates at 0 and at full scale 2^bits−1 and never wraps.
- R6: With fixed_delta=0, the step is halved (rounding down, never below 1) after the last iteration of every cycle.
- R7: With fixed_delta=1, the step keeps its initial value for the whole conversion.
- R8: iter_cfg=0 selects 8 iterations, cyc_cfg=0 selects 8 cycles, and delta_cfg=0 selects an initial step of (full scale+1)/4.
- R9: base_hi, when nonzero, is the upper bound (clipped to full scale); when zero, the upper bound is full scale. base_lo is the lower bound, clipped to full scale and to the upper bound. The estimate starts at lo+floor((hi−lo)/2) and stays within [lo, hi].
- R10: Every setting is captured on the accepted start. Changes on the setting inputs during a conversion do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted while idle |
| cmp_bit | input | 1 | Comparator decision for the current iteration |
| res_sel | input | 2 | Output resolution select |
| iter_cfg | input | 8 | Iterations per cycle (0 = default) |
| cyc_cfg | input | 8 | Cycles per conversion (0 = default) |
| delta_cfg | input | 16 | Initial step (0 = default) |
| fixed_delta | input | 1 | Keep the step constant |
| base_lo | input | 16 | Lower baseline |
| base_hi | input | 16 | Upper baseline (0 = none) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Final estimate of the last conversion |

## Verification
The assertions check on every cycle that the estimate stays inside the captured bounds. They also check that the step is never zero and does not change in fixed mode, that busy continues until the final iteration and then drops into a single done pulse, and that result moves only with done. Only the bench scenarios show the exact final values. That covers the arithmetic of each step, the halving schedule, the defaults chosen by zero settings, the midpoint start with baselines, and the isolation from settings changed mid-conversion. For this the bench compares each cycle against a behavioural model.

// File: rtl/dm_track_pkg.sv
package dm_track_pkg;

    localparam int EST_W = 16;
    localparam int CNT_W = 8;

    typedef logic [EST_W-1:0] est_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        RES_10 = 2'd0,
        RES_12 = 2'd1,
        RES_14 = 2'd2,
        RES_16 = 2'd3
    } res_e;

    typedef struct packed {
        cnt_t iters;
        cnt_t cycles;
        est_t delta0;
        logic fixed;
        est_t lo;
        est_t hi;
    } conv_cfg_t;

    // Largest code at a given resolution: 2^(10+2*sel)-1
    function automatic est_t full_scale(res_e r);
        int bits;
        bits = 10 + 2 * int'(r);
        return est_t'((32'd1 << bits) - 32'd1);
    endfunction

    // Halve, but never below one
    function automatic est_t halve_min1(est_t d);
        est_t h;
        h = d >> 1;
        return (h == '0) ? est_t'(1) : h;
    endfunction

    function automatic est_t midpoint(est_t lo, est_t hi);
        return lo + ((hi - lo) >> 1);
    endfunction

endpackage

// File: rtl/dm_cfg_decode.sv
module dm_cfg_decode
    import dm_track_pkg::*;
#(
    parameter int DFLT_ITERS  = 8,
    parameter int DFLT_CYCLES = 8
) (
    input  logic [1:0]       res_sel,
    input  logic [CNT_W-1:0] iter_cfg,
    input  logic [CNT_W-1:0] cyc_cfg,
    input  logic [EST_W-1:0] delta_cfg,
    input  logic             fixed_delta,
    input  logic [EST_W-1:0] base_lo,
    input  logic [EST_W-1:0] base_hi,
    output conv_cfg_t        cfg,
    output est_t             init_est
);
    est_t fs;
    est_t hi_b;
    est_t lo_c;
    est_t lo_b;

    always_comb begin
        fs   = full_scale(res_e'(res_sel));
        hi_b = ((base_hi == '0) || (base_hi > fs)) ? fs : base_hi;
        lo_c = (base_lo > fs) ? fs : base_lo;
        lo_b = (lo_c > hi_b) ? hi_b : lo_c;

        cfg.iters  = (iter_cfg == '0) ? cnt_t'(DFLT_ITERS) : iter_cfg;
        cfg.cycles = (cyc_cfg == '0) ? cnt_t'(DFLT_CYCLES) : cyc_cfg;
        cfg.delta0 = (delta_cfg == '0) ? ((fs >> 2) + est_t'(1)) : delta_cfg;
        cfg.fixed  = fixed_delta;
        cfg.lo     = lo_b;
        cfg.hi     = hi_b;
        init_est   = midpoint(lo_b, hi_b);
    end
endmodule

// File: rtl/dm_sequencer.sv
module dm_sequencer
    import dm_track_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cnt_t iters_in,
    input  cnt_t cycles_in,
    output logic load,
    output logic busy,
    output logic step,
    output logic cycle_end,
    output logic last
);
    cnt_t iters_q;
    cnt_t cycles_q;
    cnt_t it_cnt;
    cnt_t cy_cnt;

    assign load      = start && !busy;
    assign step      = busy;
    assign cycle_end = busy && (it_cnt == cnt_t'(iters_q - 1'b1));
    assign last      = cycle_end && (cy_cnt == cnt_t'(cycles_q - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            iters_q  <= cnt_t'(1);
            cycles_q <= cnt_t'(1);
            it_cnt   <= '0;
            cy_cnt   <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            iters_q  <= iters_in;
            cycles_q <= cycles_in;
            it_cnt   <= '0;
            cy_cnt   <= '0;
        end else if (step) begin
            if (cycle_end) begin
                it_cnt <= '0;
                cy_cnt <= cy_cnt + 1'b1;
            end else begin
                it_cnt <= it_cnt + 1'b1;
            end
            if (last) busy <= 1'b0;
        end
    end

    // R2
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);
    // R2
    busy_ends_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R2
    iter_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (it_cnt < iters_q) && (cy_cnt < cycles_q));
endmodule

// File: rtl/dm_step_ctrl.sv
module dm_step_ctrl
    import dm_track_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  est_t delta_in,
    input  logic fixed_in,
    input  logic step,
    input  logic cycle_end,
    output est_t delta
);
    logic fixed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            delta   <= est_t'(1);
            fixed_q <= 1'b0;
        end else if (load) begin
            delta   <= delta_in;
            fixed_q <= fixed_in;
        end else if (cycle_end && !fixed_q) begin
            delta <= halve_min1(delta);
        end
    end

    // R6
    delta_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (delta != '0));
    // R6
    delta_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !fixed_q) |=> ((delta == est_t'(1)) || (delta < $past(delta))));
    // R7
    delta_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (step && fixed_q) |=> $stable(delta));
endmodule

// File: rtl/dm_estimator.sv
module dm_estimator
    import dm_track_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  est_t init_est,
    input  est_t lo_in,
    input  est_t hi_in,
    input  logic step,
    input  logic last,
    input  logic cmp_bit,
    input  est_t delta,
    output logic done,
    output est_t result
);
    est_t            est;
    est_t            lo_q;
    est_t            hi_q;
    est_t            nxt;
    logic [EST_W:0]  up_sum;

    always_comb begin
        up_sum = {1'b0, est} + {1'b0, delta};
        if (cmp_bit) begin
            nxt = (up_sum > {1'b0, hi_q}) ? hi_q : up_sum[EST_W-1:0];
        end else begin
            nxt = ((est - lo_q) < delta) ? lo_q : (est - delta);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            est    <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= step && last;
            if (load) begin
                est  <= init_est;
                lo_q <= lo_in;
                hi_q <= hi_in;
            end else if (step) begin
                est <= nxt;
                if (last) result <= nxt;
            end
        end
    end

    // R9
    est_in_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> ((est >= lo_q) && (est <= hi_q)));
    // R5
    result_in_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((result >= lo_q) && (result <= hi_q)));
    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);
endmodule

// File: rtl/dm_track_ctrl.sv
module dm_track_ctrl
    import dm_track_pkg::*;
#(
    parameter int DFLT_ITERS  = 8,
    parameter int DFLT_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_bit,
    input  logic [1:0]       res_sel,
    input  logic [CNT_W-1:0] iter_cfg,
    input  logic [CNT_W-1:0] cyc_cfg,
    input  logic [EST_W-1:0] delta_cfg,
    input  logic             fixed_delta,
    input  logic [EST_W-1:0] base_lo,
    input  logic [EST_W-1:0] base_hi,
    output logic             busy,
    output logic             done,
    output logic [EST_W-1:0] result
);
    conv_cfg_t cfg;
    est_t      init_est;
    est_t      delta;
    logic      load;
    logic      step;
    logic      cycle_end;
    logic      last;

    dm_cfg_decode #(
        .DFLT_ITERS (DFLT_ITERS),
        .DFLT_CYCLES(DFLT_CYCLES)
    ) u_dec (
        .res_sel    (res_sel),
        .iter_cfg   (iter_cfg),
        .cyc_cfg    (cyc_cfg),
        .delta_cfg  (delta_cfg),
        .fixed_delta(fixed_delta),
        .base_lo    (base_lo),
        .base_hi    (base_hi),
        .cfg        (cfg),
        .init_est   (init_est)
    );

    dm_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .iters_in (cfg.iters),
        .cycles_in(cfg.cycles),
        .load     (load),
        .busy     (busy),
        .step     (step),
        .cycle_end(cycle_end),
        .last     (last)
    );

    dm_step_ctrl u_step (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .delta_in (cfg.delta0),
        .fixed_in (cfg.fixed),
        .step     (step),
        .cycle_end(cycle_end),
        .delta    (delta)
    );

    dm_estimator u_est (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .init_est(init_est),
        .lo_in   (cfg.lo),
        .hi_in   (cfg.hi),
        .step    (step),
        .last    (last),
        .cmp_bit (cmp_bit),
        .delta   (delta),
        .done    (done),
        .result  (result)
    );

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/sim_dm_track_ctrl.sv
module sim_dm_track_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmp_bit = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic [7:0]  iter_cfg = 8'd0;
    logic [7:0]  cyc_cfg = 8'd0;
    logic [15:0] delta_cfg = 16'd0;
    logic        fixed_delta = 1'b0;
    logic [15:0] base_lo = 16'd0;
    logic [15:0] base_hi = 16'd0;
    logic        busy;
    logic        done;
    logic [15:0] result;

    int  errors = 0;
    int  checks = 0;
    int  exp_result = 0;
    bit  finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    dm_track_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .cmp_bit(cmp_bit),
        .res_sel(res_sel), .iter_cfg(iter_cfg), .cyc_cfg(cyc_cfg),
        .delta_cfg(delta_cfg), .fixed_delta(fixed_delta),
        .base_lo(base_lo), .base_hi(base_hi),
        .busy(busy), .done(done), .result(result)
    );

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    task automatic check(input bit eb, input bit ed, input int er, input string tag);
        checks++;
        if (busy !== eb) begin
            errors++;
            $display("FAIL R2 (%s) busy=%b expected %b at %0t", tag, busy, eb, $time);
        end
        checks++;
        if (done !== ed) begin
            errors++;
            $display("FAIL R3 (%s) done=%b expected %b at %0t", tag, done, ed, $time);
        end
        checks++;
        if (result !== 16'(er)) begin
            errors++;
            $display("FAIL %s result=%0d expected %0d at %0t", tag, result, er, $time);
        end
    endtask

    // pat: 0 all ones, 1 all zeros, 2 alternating, 3 pseudo-random, 4 track target
    task automatic run_conv(input int res, input int it, input int cy, input int dl,
                            input bit fx, input int blo, input int bhi,
                            input int pat, input int target, input bit scramble,
                            input string tag);
        int fs, hi, lo, d, ni, nc, est, k;
        bit c, lst;
        fs = (1 << (10 + 2 * res)) - 1;
        hi = ((bhi == 0) || (bhi > fs)) ? fs : bhi;
        lo = (blo > fs) ? fs : blo;
        if (lo > hi) lo = hi;
        d  = (dl == 0) ? (fs + 1) / 4 : dl;
        ni = (it == 0) ? 8 : it;
        nc = (cy == 0) ? 8 : cy;
        est = lo + (hi - lo) / 2;
        k = 0;

        @(negedge clk);
        res_sel = 2'(res); iter_cfg = 8'(it); cyc_cfg = 8'(cy);
        delta_cfg = 16'(dl); fixed_delta = fx;
        base_lo = 16'(blo); base_hi = 16'(bhi);
        start = 1'b1; cmp_bit = 1'b0;
        @(posedge clk); #1;
        check(1'b1, 1'b0, exp_result, tag);

        for (int ci = 0; ci < nc; ci++) begin
            for (int ii = 0; ii < ni; ii++) begin
                @(negedge clk);
                case (pat)
                    0: c = 1'b1;
                    1: c = 1'b0;
                    2: c = k[0];
                    3: c = next_rand() % 2 == 1;
                    default: c = (est < target);
                endcase
                k++;
                cmp_bit = c;
                if (scramble) begin
                    start = next_rand() % 2 == 1;
                    res_sel = 2'(next_rand()); iter_cfg = 8'(next_rand());
                    cyc_cfg = 8'(next_rand()); delta_cfg = 16'(next_rand());
                    fixed_delta = next_rand() % 2 == 1;
                    base_lo = 16'(next_rand()); base_hi = 16'(next_rand());
                end else begin
                    start = 1'b0;
                end
                if (c) est = (est + d > hi) ? hi : est + d;
                else   est = (est - lo < d) ? lo : est - d;
                lst = (ci == nc - 1) && (ii == ni - 1);
                if (lst) exp_result = est;
                if (!fx && ii == ni - 1) begin
                    d = d / 2;
                    if (d < 1) d = 1;
                end
                @(posedge clk); #1;
                check(!lst, lst, exp_result, tag);
            end
        end
        @(negedge clk);
        start = 1'b0;
        @(posedge clk); #1;
        check(1'b0, 1'b0, exp_result, tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog expired busy=%b expected 0", busy);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        // R1: reset state
        check(1'b0, 1'b0, 0, "R1");

        // R4: up/down steps with a fixed step, alternating decisions
        run_conv(0, 4, 2, 10, 1'b1, 0, 0, 2, 0, 1'b0, "R4");
        run_conv(1, 3, 3, 37, 1'b1, 0, 0, 3, 0, 1'b0, "R4");
        // R5: saturation at full scale and at zero
        run_conv(0, 2, 2, 300, 1'b1, 0, 0, 0, 0, 1'b0, "R5");
        run_conv(1, 4, 2, 900, 1'b1, 0, 0, 1, 0, 1'b0, "R5");
        run_conv(3, 4, 4, 20000, 1'b1, 0, 0, 0, 0, 1'b0, "R5");
        // R6: halving per cycle, floor at one
        run_conv(3, 3, 6, 1000, 1'b0, 0, 0, 3, 0, 1'b0, "R6");
        run_conv(0, 2, 5, 2, 1'b0, 0, 0, 0, 0, 1'b0, "R6");
        // R7: fixed step over many cycles
        run_conv(2, 5, 3, 7, 1'b1, 0, 0, 3, 0, 1'b0, "R7");
        // R8: zero settings pick the defaults
        run_conv(2, 0, 0, 0, 1'b0, 0, 0, 4, 5000, 1'b0, "R8");
        run_conv(0, 0, 0, 0, 1'b0, 0, 0, 3, 0, 1'b0, "R8");
        // R9: baselines bound and seed the estimate
        run_conv(0, 4, 3, 50, 1'b1, 100, 300, 0, 0, 1'b0, "R9");
        run_conv(0, 4, 3, 50, 1'b1, 100, 0, 1, 0, 1'b0, "R9");
        run_conv(0, 3, 2, 40, 1'b0, 900, 5000, 0, 0, 1'b0, "R9");
        run_conv(1, 2, 2, 10, 1'b1, 600, 500, 3, 0, 1'b0, "R9");
        // R10: settings and start toggled mid-conversion are ignored
        run_conv(1, 6, 4, 200, 1'b0, 50, 3000, 3, 0, 1'b1, "R10");
        run_conv(0, 0, 0, 0, 1'b1, 0, 0, 3, 0, 1'b1, "R10");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule